// File: doc/BRIEF.md
# PCI DMA Address Translator

This block turns the address carried by an inbound PCI DMA request into a system memory address. It also produces a byte-swap indication for the transfer. The address is picked apart into one of three paths.

- **Flat 64-bit path.** A 64-bit request whose marker bit is set is passed straight through.
- **Direct window.** A 32-bit request in the upper half of the 32-bit space is relocated linearly. It lands at a programmable base plus its offset.
- **Translated window.** A 32-bit request in the lower half is resolved through an on-chip table of page entries. Each entry can point at any page of system memory.

A request that matches no path, lands on an empty table entry, or indexes past the end of the table is flagged as a fault. A faulted request gives no address.

The table and three configuration values are loaded through a simple write port. The three values are the window base, a per-device swap mask and the page size. The page size is shared by every entry and is either 4 KB or 16 KB. It decides which address bits form the table index.

For the translated window, the swap choice comes from which of two aliases of the same entry the device used. For the direct window, it comes from the requesting device's bit in the swap mask. Every result is registered, so it appears one cycle after the request.

Top module: `dmaxl_top`

## Requirements
- R1: A request with `reqDma64`=1 and `reqAddr[56]`=1 returns `outAddr` = `reqAddr[SYS_AW-1:0]` with `outSwap`=0.
- R2: A request with `reqDma64`=1 and `reqAddr[56]`=0 returns a fault.
- R3: A request with `reqDma64`=0 and `reqAddr[31]`=1 returns `outAddr` = window base + `reqAddr[30:0]` (modulo 2^SYS_AW) and `outSwap` = bit `reqDev` of the swap mask.
  - Bits 63:32 are ignored for this path.
  - The window base is written with `ctrlSel`=0 from `ctrlData[SYS_AW-1:0]`.
  - The swap mask is written with `ctrlSel`=1 from `ctrlData[NUM_DEV-1:0]`.
- R4: A request with `reqDma64`=0 and `reqAddr[31]`=0 is translated.
  - The page number is `reqAddr[29:12]` with 4 KB pages, or `reqAddr[29:14]` with 16 KB pages.
  - `outSwap` = `reqAddr[30]`, so both aliases reach the same entry.
  - With 4 KB pages, `outAddr` = {frame, `reqAddr[11:0]`}.
  - With 16 KB pages, `outAddr` = {frame[FRAME_W-1:2], `reqAddr[13:0]`}.
- R5: The page size is written with `ctrlSel`=2: `ctrlData[0]`=1 selects 16 KB and 0 selects 4 KB. `ctrlSel`=3 writes nothing.
- R6: A translated request faults when its page number is not below NUM_ENTRIES, or when the selected entry is invalid.
  - A table write puts `tblData[FRAME_W]` in the valid bit and `tblData[FRAME_W-1:0]` in the frame of entry `tblWrIdx`.
- R7: One cycle after a request, exactly one of `outValid` and `outFault` is high.
  - After a cycle with no request, both are low.
  - On a fault or an idle cycle, `outAddr` and `outSwap` are 0.
- R8: A table or configuration write takes effect for requests issued in later cycles. A request in the same cycle as the write still sees the old contents.
- R9: Reset clears the outputs and every table valid bit. It also sets the base to 0, the swap mask to 0 and the page size to 4 KB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | 64 | PCI DMA address |
| reqDma64 | input | 1 | Request is a 64-bit address cycle |
| reqDev | input | DEV_W | Requesting device number |
| tblWe | input | 1 | Table entry write strobe |
| tblWrIdx | input | IDX_W | Table entry being written |
| tblData | input | FRAME_W+1 | Valid bit and frame number |
| ctrlWe | input | 1 | Configuration write strobe |
| ctrlSel | input | 2 | Configuration target: 0 base, 1 swap mask, 2 page size |
| ctrlData | input | 64 | Configuration value |
| outValid | output | 1 | Translated address valid |
| outFault | output | 1 | Request faulted |
| outAddr | output | SYS_AW | System address |
| outSwap | output | 1 | Byte swap for this transfer |

## Verification
The bench targets the edges of the translated window:
- The last table index under both page sizes.
- The first page number past the table, which a design with a loose range check would translate instead of faulting.
- The two swap aliases, which a design that lets bit 30 leak into the index would send to different entries.

With 16 KB pages, bits 13:12 must come from the address and not from the frame. A design that mixed them up would return misaligned addresses.

A write and a request to the same entry in one cycle must show the old entry. A bypassing design would show the new one.

Direct-window requests from each device check the swap-mask indexing. Flat requests with and without the marker bit check the fault on the 64-bit path.

// File: rtl/dmaxl_pkg.sv
package dmaxl_pkg;
  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_FLAT64 = 2'd1,
    MODE_WINDOW = 2'd2,
    MODE_TABLE  = 2'd3
  } xlMode_t;

  typedef struct packed {
    logic    load;
    logic    fault;
    xlMode_t mode;
    logic    swap;
  } xlStrobe_t;
endpackage

// File: rtl/dmaxl_ctrl.sv
module dmaxl_ctrl
  import dmaxl_pkg::*;
#(
  parameter int NUM_ENTRIES = 128,
  parameter int NUM_DEV     = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int DEV_W      = $clog2(NUM_DEV)
) (
  input  logic               reqValid,
  input  logic [63:0]        reqAddr,
  input  logic               reqDma64,
  input  logic [DEV_W-1:0]   reqDev,
  input  logic               pageBig,
  input  logic [NUM_DEV-1:0] devSwap,
  input  logic               entryValid,
  output logic [IDX_W-1:0]   lookIdx,
  output xlStrobe_t          strobe
);
  localparam int PN_W = 18;

  logic [PN_W-1:0] pageNum;
  logic            pastEnd;

  // Page number of a translated-window address; width depends on page size.
  assign pageNum = pageBig ? {2'b00, reqAddr[29:14]} : reqAddr[29:12];
  assign lookIdx = pageNum[IDX_W-1:0];
  assign pastEnd = |(pageNum >> IDX_W);

  always_comb begin
    strobe      = '0;
    strobe.load = reqValid;
    if (reqValid) begin
      if (reqDma64) begin
        if (reqAddr[56]) strobe.mode = MODE_FLAT64;
        else             strobe.fault = 1'b1;
      end else if (reqAddr[31]) begin
        strobe.mode = MODE_WINDOW;
        strobe.swap = devSwap[reqDev];
      end else if (pastEnd || !entryValid) begin
        strobe.fault = 1'b1;
      end else begin
        strobe.mode = MODE_TABLE;
        strobe.swap = reqAddr[30];
      end
    end
  end
endmodule

// File: rtl/dmaxl_dp.sv
module dmaxl_dp
  import dmaxl_pkg::*;
#(
  parameter int NUM_ENTRIES = 128,
  parameter int NUM_DEV     = 8,
  parameter int SYS_AW      = 48,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int FRAME_W    = SYS_AW - 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlStrobe_t          strobe,
  input  logic [IDX_W-1:0]   lookIdx,
  input  logic [63:0]        reqAddr,
  input  logic               tblWe,
  input  logic [IDX_W-1:0]   tblWrIdx,
  input  logic [FRAME_W:0]   tblData,
  input  logic               ctrlWe,
  input  logic [1:0]         ctrlSel,
  input  logic [63:0]        ctrlData,
  output logic               entryValid,
  output logic               pageBig,
  output logic [NUM_DEV-1:0] devSwap,
  output logic               outValid,
  output logic               outFault,
  output logic [SYS_AW-1:0]  outAddr,
  output logic               outSwap
);
  logic [FRAME_W-1:0]     frameMem [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validVec;
  logic [SYS_AW-1:0]      winBase;
  logic [FRAME_W-1:0]     hitFrame;
  logic [SYS_AW-1:0]      nextAddr;
  logic                   good;

  assign entryValid = validVec[lookIdx];
  assign hitFrame   = frameMem[lookIdx];
  assign good       = strobe.load && !strobe.fault;

  always_comb begin
    case (strobe.mode)
      MODE_FLAT64: nextAddr = reqAddr[SYS_AW-1:0];
      MODE_WINDOW: nextAddr = winBase + {{(SYS_AW-31){1'b0}}, reqAddr[30:0]};
      MODE_TABLE:  nextAddr = pageBig ? {hitFrame[FRAME_W-1:2], reqAddr[13:0]}
                                      : {hitFrame, reqAddr[11:0]};
      default:     nextAddr = '0;
    endcase
  end

  // Frame storage carries no reset; only the valid bits do.
  always_ff @(posedge clk) begin
    if (tblWe) frameMem[tblWrIdx] <= tblData[FRAME_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      winBase  <= '0;
      devSwap  <= '0;
      pageBig  <= 1'b0;
    end else begin
      if (tblWe) validVec[tblWrIdx] <= tblData[FRAME_W];
      if (ctrlWe) begin
        case (ctrlSel)
          2'd0:    winBase <= ctrlData[SYS_AW-1:0];
          2'd1:    devSwap <= ctrlData[NUM_DEV-1:0];
          2'd2:    pageBig <= ctrlData[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outFault <= 1'b0;
      outAddr  <= '0;
      outSwap  <= 1'b0;
    end else begin
      outValid <= good;
      outFault <= strobe.load && strobe.fault;
      outAddr  <= good ? nextAddr : '0;
      outSwap  <= good && strobe.swap;
    end
  end

  a_r7_one_hot_result: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outFault));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> (!outValid && !outFault && outAddr == '0));

  a_r9_empty_after_reset: assert property (@(posedge clk)
    !rstN |=> validVec == '0);
endmodule

// File: rtl/dmaxl_top.sv
module dmaxl_top
  import dmaxl_pkg::*;
#(
  parameter int NUM_ENTRIES = 128,
  parameter int NUM_DEV     = 8,
  parameter int SYS_AW      = 48,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int DEV_W      = $clog2(NUM_DEV),
  localparam int FRAME_W    = SYS_AW - 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [63:0]       reqAddr,
  input  logic              reqDma64,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic              tblWe,
  input  logic [IDX_W-1:0]  tblWrIdx,
  input  logic [FRAME_W:0]  tblData,
  input  logic              ctrlWe,
  input  logic [1:0]        ctrlSel,
  input  logic [63:0]       ctrlData,
  output logic              outValid,
  output logic              outFault,
  output logic [SYS_AW-1:0] outAddr,
  output logic              outSwap
);
  xlStrobe_t          strobe;
  logic [IDX_W-1:0]   lookIdx;
  logic               entryValid;
  logic               pageBig;
  logic [NUM_DEV-1:0] devSwap;

  dmaxl_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_DEV(NUM_DEV)) uCtrl (
    .reqValid(reqValid), .reqAddr(reqAddr), .reqDma64(reqDma64), .reqDev(reqDev),
    .pageBig(pageBig), .devSwap(devSwap), .entryValid(entryValid),
    .lookIdx(lookIdx), .strobe(strobe)
  );

  dmaxl_dp #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_DEV(NUM_DEV), .SYS_AW(SYS_AW)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookIdx(lookIdx), .reqAddr(reqAddr),
    .tblWe(tblWe), .tblWrIdx(tblWrIdx), .tblData(tblData),
    .ctrlWe(ctrlWe), .ctrlSel(ctrlSel), .ctrlData(ctrlData),
    .entryValid(entryValid), .pageBig(pageBig), .devSwap(devSwap),
    .outValid(outValid), .outFault(outFault), .outAddr(outAddr), .outSwap(outSwap)
  );

  a_r1_flat_pass: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqDma64 && reqAddr[56]) |=>
      (outValid && !outSwap && outAddr == $past(reqAddr[SYS_AW-1:0])));

  a_r2_flat_fault: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqDma64 && !reqAddr[56]) |=> outFault);

  a_r3_window_swap: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqDma64 && reqAddr[31]) |=>
      (outValid && outSwap == $past(devSwap[reqDev])));

  a_r4_alias_swap: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqDma64 && !reqAddr[31]) |=>
      (outFault || outSwap == $past(reqAddr[30])));
endmodule

// File: tb/tb_dmaxl_top.sv
module tb_dmaxl_top;
  localparam int NE = 128;
  localparam int ND = 8;
  localparam int AW = 48;
  localparam int IW = 7;
  localparam int DW = 3;
  localparam int FW = AW - 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqDma64 = 0, tblWe = 0, ctrlWe = 0;
  logic [63:0] reqAddr = '0, ctrlData = '0;
  logic [DW-1:0] reqDev = '0;
  logic [IW-1:0] tblWrIdx = '0;
  logic [FW:0] tblData = '0;
  logic [1:0] ctrlSel = '0;
  logic outValid, outFault, outSwap;
  logic [AW-1:0] outAddr;

  dmaxl_top dut (.*);

  always #5 clk = ~clk;

  // Behavioural reference state
  logic [FW-1:0] mFrame [NE];
  bit  mValid [NE];
  logic [AW-1:0] mBase = '0;
  logic [ND-1:0] mSwap = '0;
  bit  mBig = 0;

  bit eV, eF, eS;
  logic [AW-1:0] eA;
  string eTag = "R9";
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic predict();
    int pg;
    eV = 0; eF = 0; eS = 0; eA = '0; eTag = "R7";
    if (!reqValid) return;
    if (reqDma64) begin
      if (reqAddr[56]) begin eV = 1; eA = reqAddr[AW-1:0]; eTag = "R1"; end
      else begin eF = 1; eTag = "R2"; end
    end else if (reqAddr[31]) begin
      eV = 1; eA = mBase + AW'(reqAddr[30:0]); eS = mSwap[reqDev]; eTag = "R3";
    end else begin
      pg = mBig ? int'(reqAddr[29:14]) : int'(reqAddr[29:12]);
      if (pg >= NE || !mValid[pg]) begin eF = 1; eTag = "R6"; end
      else begin
        eV = 1; eS = reqAddr[30]; eTag = mBig ? "R5" : "R4";
        eA = {mFrame[pg], 12'h000};
        if (mBig) eA = (eA & ~AW'('h3000)) | AW'(reqAddr[13:0]);
        else      eA = eA | AW'(reqAddr[11:0]);
      end
    end
  endtask

  task automatic commitWrites();
    if (tblWe) begin mFrame[tblWrIdx] = tblData[FW-1:0]; mValid[tblWrIdx] = tblData[FW]; end
    if (ctrlWe) case (ctrlSel)
      2'd0: mBase = ctrlData[AW-1:0];
      2'd1: mSwap = ctrlData[ND-1:0];
      2'd2: mBig  = ctrlData[0];
      default: ;
    endcase
  endtask

  // Inputs are already applied; predict, update model, then compare after the edge.
  task automatic tick();
    predict();
    commitWrites();
    @(negedge clk);
    total++;
    if (outValid !== eV || outFault !== eF || outAddr !== eA || outSwap !== eS) begin
      bad++;
      $display("FAIL %s: got v=%0b f=%0b a=%h s=%0b exp v=%0b f=%0b a=%h s=%0b",
               eTag, outValid, outFault, outAddr, outSwap, eV, eF, eA, eS);
    end
    reqValid = 0; tblWe = 0; ctrlWe = 0;
  endtask

  task automatic wrCtrl(input logic [1:0] s, input logic [63:0] d);
    ctrlWe = 1; ctrlSel = s; ctrlData = d; tick();
  endtask

  task automatic wrTbl(input int i, input bit v, input logic [FW-1:0] f);
    tblWe = 1; tblWrIdx = IW'(i); tblData = {v, f}; tick();
  endtask

  task automatic req(input bit d64, input logic [63:0] a, input int dev);
    reqValid = 1; reqDma64 = d64; reqAddr = a; reqDev = DW'(dev); tick();
  endtask

  function automatic logic [63:0] tAddr(bit alias1, int pg, int off);
    logic [63:0] a = '0;
    a[30] = alias1;
    if (mBig) a[29:14] = 16'(pg); else a[29:12] = 18'(pg);
    a = a | 64'(off & (mBig ? 'h3fff : 'hfff));
    return a;
  endfunction

  initial begin
    for (int i = 0; i < NE; i++) begin mValid[i] = 0; mFrame[i] = '0; end
    repeat (3) @(negedge clk);
    total++;
    if (outValid !== 0 || outFault !== 0 || outAddr !== '0 || outSwap !== 0) begin
      bad++; $display("FAIL R9: reset outputs v=%0b f=%0b a=%h s=%0b exp all 0",
                      outValid, outFault, outAddr, outSwap);
    end
    rstN = 1;
    // R9: empty table after reset faults
    req(0, tAddr(0, 0, 0), 0);
    req(0, 64'h8000_0010, 2);                      // R9 base 0, mask 0
    wrCtrl(0, 64'h0000_1234_0000_0000);
    wrCtrl(1, 64'h0000_0000_0000_00A5);
    for (int d = 0; d < ND; d++) req(0, 64'hFFFF_0000_8000_0000 | 64'(d * 'h111), d); // R3
    req(1, 64'h0100_ABCD_1234_5678, 0);            // R1
    req(1, 64'h0000_ABCD_1234_5678, 0);            // R2
    wrTbl(5, 1, 36'h0_ABCD_E);
    wrTbl(NE - 1, 1, 36'h7_7777_3);
    wrTbl(9, 0, 36'h1_1111_1);
    req(0, tAddr(0, 5, 'h3a5), 1);                 // R4 alias 0
    req(0, tAddr(1, 5, 'h3a5), 1);                 // R4 alias 1
    req(0, tAddr(0, NE - 1, 'hfff), 0);            // R4 last index
    req(0, tAddr(0, NE, 0), 0);                    // R6 past end
    req(0, tAddr(0, 9, 0), 0);                     // R6 invalid
    // R8: write and request in same cycle sees old entry
    tblWe = 1; tblWrIdx = 9; tblData = {1'b1, 36'h2_2222_2};
    reqValid = 1; reqDma64 = 0; reqAddr = tAddr(0, 9, 4); tick();
    req(0, tAddr(0, 9, 4), 0);
    wrCtrl(3, 64'h1);                              // R5 sel 3 no effect
    req(0, tAddr(0, 5, 'h2ff), 0);
    wrCtrl(2, 64'h1);                              // R5 16 KB
    wrTbl(1, 1, 36'h0_ABCD_F);
    req(0, tAddr(0, 1, 'h3abc), 3);                // R5
    req(1, tAddr(1, 1, 'h3abc), 3);                // R2 with 64-bit flag
    req(0, tAddr(1, NE - 1, 'h3fff), 3);           // R5 last index
    req(0, tAddr(0, NE, 0), 3);                    // R6 past end
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 9);
      if (k == 0) wrTbl($urandom_range(0, NE - 1), ($urandom_range(0, 3) != 0), FW'({$urandom, $urandom}));
      else if (k == 1) wrCtrl(2'($urandom_range(0, 3)), {$urandom, $urandom});
      else if (k == 2) tick();
      else begin
        reqValid = 1; reqDev = DW'($urandom);
        reqDma64 = ($urandom_range(0, 4) == 0);
        if (reqDma64) reqAddr = {$urandom, $urandom};
        else if ($urandom_range(0, 2) == 0) reqAddr = {$urandom, 1'b1, 31'($urandom)};
        else reqAddr = tAddr($urandom_range(0, 1), $urandom_range(0, NE + 3), $urandom);
        if ($urandom_range(0, 7) == 0) begin
          tblWe = 1; tblWrIdx = IW'($urandom); tblData = {1'b1, FW'({$urandom, $urandom})};
        end
        tick();
      end
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R7: watchdog expired got running exp done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule